// File: doc/BRIEF.md
# Loopback Pulse-Count Connectivity Tester

This block checks the wiring of a board through a loopback cable. It visits the differential output pairs one after another. For each pair it sends a burst of exactly `BURST_LEN` single-cycle pulses on that pair while every other output stays low. It then counts the rising edges that come back on all returned inputs.

The input that belongs to the driven pair must see the exact burst count, or the pair is marked open/miscounted. Any edge on any other input during that step marks the pair as shorted. Each pair's record goes out on a capture-RAM write port at the end of its step and is also kept for readback. After the last pair the block writes one go/no-go word and raises done. Software starts a run and reads status and per-pair records through a small register port.

Top module: `loop_pulse_tester`

## Requirements
- R1: After reset, busy, done and the pass bit read 0, every txPulse bit is 0 and ramWrEn is 0.
- R2: A write with regAddr[IDX_W]=0 and regWrData[0]=1 while idle starts a run. It clears done, and busy stays 1 from the next cycle until the summary cycle ends. Done then rises while busy falls. The same write while busy has no effect on outputs or timing.
- R3: Pairs are tested in ascending index order, one at a time. Each step is laid out as follows:
  - one clear cycle;
  - 2*BURST_LEN burst cycles, with txPulse of the pair under test high on the first, third, fifth and later odd-numbered cycles, so it carries exactly BURST_LEN pulses;
  - SETTLE quiet cycles;
  - one record cycle.
  All other txPulse bits stay 0.
- R4: Each returned input passes through a two-flop synchronizer and its rising edges are counted. Counters are cleared in the clear cycle of each step. The count for the pair under test is recorded in result bits 15:8. Bit 0 (open/miscount) is 0 only if that count equals BURST_LEN exactly.
- R5: The edge counters saturate at 255, so a line toggling far more than the burst yields count 255 with bit 0 set.
- R6: Result bit 1 (short) is set when any input other than the one under test shows a rising edge during that step. Bits 7:2 are 0.
- R7: In each record cycle ramWrEn is 1, ramWrAddr equals the pair index, and ramWrData is that pair's result word.
- R8: In the cycle after the last record cycle, ramWrEn is 1, ramWrAddr equals NUM_CH, and ramWrData bit 0 is the go/no-go flag, with all other bits 0.
- R9: With regAddr[IDX_W]=0, regRdData is the status word: bit 0 busy, bit 1 done, bit 2 pass, and all other bits 0. With regAddr[IDX_W]=1, regRdData is the stored result word of pair regAddr[IDX_W-1:0].
- R10: The pass/go flag is 1 only when done is 1 and every pair of the run had both bit 0 and bit 1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | IDX_W+1 | Register address (top bit selects result words) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| txPulse | output | NUM_CH | Drive to the output pairs |
| rxLine | input | NUM_CH | Returned inputs from the loopback cable |
| ramWrEn | output | 1 | Capture RAM write enable |
| ramWrAddr | output | RAM_AW | Capture RAM word address |
| ramWrData | output | 16 | Capture RAM write data |

## Verification
The bench builds the block with NUM_CH=4, BURST_LEN=64 and SETTLE=400. Four pairs are enough to place an open, an adjacent short and a noisy line at different positions in the sequence. The long settle gap widens each counting window to 528 cycles. A free-toggling line then produces more than 255 edges, so saturation can be reached within a short run. Each scenario is compared cycle by cycle against a timeline model, and a start write is issued in the middle of a run.

// File: rtl/ltst_pkg.sv
package ltst_pkg;
  localparam int CNT_W = 8;
  localparam int RES_W = 16;

  typedef struct packed {
    logic runStart;
    logic clrCnt;
    logic drive;
    logic latch;
    logic summary;
  } ltst_strobe_t;
endpackage

// File: rtl/ltst_ctrl.sv
module ltst_ctrl
  import ltst_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int BURST_LEN = 64,
  parameter int SETTLE    = 8,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int STEP_W   = $clog2(2 * BURST_LEN + SETTLE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWr,
  output ltst_strobe_t     strobe,
  output logic [IDX_W-1:0] chSel,
  output logic             busy,
  output logic             done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_BURST, ST_SETTLE, ST_LATCH, ST_FINISH
  } state_t;

  localparam logic [STEP_W-1:0] BURST_LAST  = STEP_W'(2 * BURST_LEN - 1);
  localparam logic [STEP_W-1:0] SETTLE_LAST = STEP_W'(SETTLE - 1);
  localparam logic [IDX_W-1:0]  CH_LAST     = IDX_W'(NUM_CH - 1);

  state_t            state;
  logic [STEP_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      chSel   <= '0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startWr) begin
            state <= ST_CLEAR;
            chSel <= '0;
            done  <= 1'b0;
          end
        end
        ST_CLEAR: begin
          state   <= ST_BURST;
          stepCnt <= '0;
        end
        ST_BURST: begin
          if (stepCnt == BURST_LAST) begin
            state   <= ST_SETTLE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + STEP_W'(1);
          end
        end
        ST_SETTLE: begin
          if (stepCnt == SETTLE_LAST) state <= ST_LATCH;
          else stepCnt <= stepCnt + STEP_W'(1);
        end
        ST_LATCH: begin
          if (chSel == CH_LAST) begin
            state <= ST_FINISH;
          end else begin
            chSel <= chSel + IDX_W'(1);
            state <= ST_CLEAR;
          end
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.runStart = (state == ST_IDLE) && startWr;
    strobe.clrCnt   = (state == ST_CLEAR);
    strobe.drive    = (state == ST_BURST) && !stepCnt[0];
    strobe.latch    = (state == ST_LATCH);
    strobe.summary  = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy); // R2
  AST_SUMMARY_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.summary |-> ($past(strobe.latch) && chSel == CH_LAST)); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startWr && !strobe.summary && !strobe.latch) |=> busy); // R2
endmodule

// File: rtl/ltst_datapath.sv
module ltst_datapath
  import ltst_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int BURST_LEN = 64,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RAM_AW   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ltst_strobe_t      strobe,
  input  logic [IDX_W-1:0]  chSel,
  input  logic [NUM_CH-1:0] rxLine,
  output logic [NUM_CH-1:0] txPulse,
  output logic              ramWrEn,
  output logic [RAM_AW-1:0] ramWrAddr,
  output logic [RES_W-1:0]  ramWrData,
  output logic              passAcc,
  input  logic [IDX_W-1:0]  resRdIdx,
  output logic [RES_W-1:0]  resRdWord
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_EXP = CNT_W'(BURST_LEN);

  logic [NUM_CH-1:0] selMask;
  logic [NUM_CH-1:0] rxMeta, rxSync, rxPrev, rxRise;
  logic [CNT_W-1:0]  tgtCnt, strayCnt;
  logic              tgtInc, strayInc, openBit, shortBit;
  logic [RES_W-1:0]  curWord;
  logic [RES_W-1:0]  resWord [NUM_CH];

  assign selMask = NUM_CH'(1) << chSel;
  assign txPulse = strobe.drive ? selMask : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rxMeta[g] <= 1'b0;
        rxSync[g] <= 1'b0;
        rxPrev[g] <= 1'b0;
      end else begin
        rxMeta[g] <= rxLine[g];
        rxSync[g] <= rxMeta[g];
        rxPrev[g] <= rxSync[g];
      end
    end
    assign rxRise[g] = rxSync[g] & ~rxPrev[g];
  end

  assign tgtInc   = |(rxRise & selMask);
  assign strayInc = |(rxRise & ~selMask);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCnt) begin
      tgtCnt   <= '0;
      strayCnt <= '0;
    end else begin
      if (tgtInc && tgtCnt != CNT_MAX) tgtCnt <= tgtCnt + CNT_W'(1);
      if (strayInc && strayCnt != CNT_MAX) strayCnt <= strayCnt + CNT_W'(1);
    end
  end

  assign openBit  = (tgtCnt != CNT_EXP);
  assign shortBit = (strayCnt != '0);
  assign curWord  = {tgtCnt, {(RES_W - CNT_W - 2){1'b0}}, shortBit, openBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passAcc <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) resWord[i] <= '0;
    end else begin
      if (strobe.runStart) passAcc <= 1'b1;
      else if (strobe.latch) passAcc <= passAcc & ~openBit & ~shortBit;
      if (strobe.latch) resWord[chSel] <= curWord;
    end
  end

  always_comb begin
    ramWrEn   = strobe.latch | strobe.summary;
    ramWrAddr = strobe.summary ? RAM_AW'(NUM_CH) : RAM_AW'(chSel);
    ramWrData = strobe.summary ? {{(RES_W - 1){1'b0}}, passAcc} : curWord;
  end

  assign resRdWord = resWord[resRdIdx];

  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txPulse)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (tgtCnt == '0 && strayCnt == '0)); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (tgtCnt == CNT_MAX && !strobe.clrCnt) |=> tgtCnt == CNT_MAX); // R5
  AST_RAM_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> ramWrAddr <= RAM_AW'(NUM_CH)); // R7
  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (strayCnt != '0 && !strobe.clrCnt) |=> strayCnt != '0); // R6
endmodule

// File: rtl/loop_pulse_tester.sv
module loop_pulse_tester
  import ltst_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int BURST_LEN = 64,
  parameter int SETTLE    = 8,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RAM_AW   = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W:0]    regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic [NUM_CH-1:0] txPulse,
  input  logic [NUM_CH-1:0] rxLine,
  output logic              ramWrEn,
  output logic [RAM_AW-1:0] ramWrAddr,
  output logic [15:0]       ramWrData
);
  ltst_strobe_t     strobe;
  logic [IDX_W-1:0] chSel;
  logic             busy, done, passAcc, startWr, passBit;
  logic [RES_W-1:0] resRdWord;

  assign startWr = regWrEn && !regAddr[IDX_W] && regWrData[0];
  assign passBit = done && passAcc;

  ltst_ctrl #(.NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN), .SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .strobe(strobe),
    .chSel(chSel), .busy(busy), .done(done)
  );

  ltst_datapath #(.NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chSel(chSel), .rxLine(rxLine),
    .txPulse(txPulse), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData), .passAcc(passAcc),
    .resRdIdx(regAddr[IDX_W-1:0]), .resRdWord(resRdWord)
  );

  assign regRdData = regAddr[IDX_W] ? resRdWord
                                    : {13'b0, passBit, done, busy};

  AST_PASS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    passBit |-> !busy); // R10
endmodule

// File: tb/test_loop_pulse_tester.sv
module test_loop_pulse_tester;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int BURST_LEN  = 64;
  localparam int SETTLE     = 400;
  localparam int IDX_W      = 2;
  localparam int RAM_AW     = 3;
  localparam int STEP       = 2 * BURST_LEN + SETTLE + 2;
  localparam int RUN_END    = NUM_CH * STEP;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [IDX_W:0]    regAddr = '0;
  logic [15:0]       regWrData = '0;
  logic [15:0]       regRdData;
  logic [NUM_CH-1:0] txPulse;
  logic [NUM_CH-1:0] rxLine;
  logic              ramWrEn;
  logic [RAM_AW-1:0] ramWrAddr;
  logic [15:0]       ramWrData;

  int faultMode = 0;  // 0 clean, 1 open pair 2, 2 short 0-1, 3 noise on 3
  logic noiseBit = 1'b0;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  loop_pulse_tester #(.NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN), .SETTLE(SETTLE)) i_loop_pulse_tester (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txPulse(txPulse),
    .rxLine(rxLine), .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr),
    .ramWrData(ramWrData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) noiseBit <= ~noiseBit;

  always_comb begin
    rxLine = txPulse;
    case (faultMode)
      1: rxLine[2] = 1'b0;
      2: begin
        rxLine[0] = txPulse[0] | txPulse[1];
        rxLine[1] = txPulse[0] | txPulse[1];
      end
      3: rxLine[3] = noiseBit;
      default: ;
    endcase
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expWord(int mode, int c);
    int cnt = 64;
    int sh = 0;
    if (mode == 1 && c == 2) cnt = 0;
    if (mode == 3 && c == 3) cnt = 255;
    if (mode == 2 && c <= 1) sh = 1;
    if (mode == 3 && c != 3) sh = 1;
    return (cnt << 8) | (sh << 1) | ((cnt != BURST_LEN) ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 60000) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 60000);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic runScenario(input int mode, input bit restartMid);
    faultMode = mode;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = '0; regWrData = 16'h0001;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    for (int t = 0; t <= RUN_END + 2; t++) begin
      int step = t / STEP;
      int off = t % STEP;
      int eTx = 0, eRam = 0, eAddr = 0, eData = 0, eBusy, eDone, ePass;
      bit allPass = (mode == 0);
      if (t < RUN_END) begin
        if (off >= 1 && off <= 2 * BURST_LEN && ((off - 1) % 2) == 0) eTx = 1 << step;
        if (off == STEP - 1) begin
          eRam = 1; eAddr = step; eData = expWord(mode, step);
        end
      end else if (t == RUN_END) begin
        eRam = 1; eAddr = NUM_CH; eData = allPass ? 1 : 0;
      end
      eBusy = (t <= RUN_END) ? 1 : 0;
      eDone = (t > RUN_END) ? 1 : 0;
      ePass = (t > RUN_END && allPass) ? 1 : 0;
      #1;
      check(txPulse == NUM_CH'(eTx), "R3", "txPulse", txPulse, eTx);
      check(regRdData == 16'((ePass << 2) | (eDone << 1) | eBusy),
            (t > RUN_END) ? "R10" : "R2", "status", regRdData,
            (ePass << 2) | (eDone << 1) | eBusy);
      check(ramWrEn == eRam, "R7", "ramWrEn", ramWrEn, eRam);
      if (eRam == 1) begin
        check(ramWrAddr == RAM_AW'(eAddr), (t == RUN_END) ? "R8" : "R7",
              "ramWrAddr", ramWrAddr, eAddr);
        check(ramWrData == 16'(eData),
              (t == RUN_END) ? "R8" : ((mode == 3 && eAddr == 3) ? "R5" :
                                      ((mode == 2 || mode == 3) ? "R6" : "R4")),
              "ramWrData", ramWrData, eData);
      end
      if (restartMid && t == 300) begin
        regWrEn = 1'b1; regAddr = '0; regWrData = 16'h0001;  // ignored while busy, R2
      end else begin
        regWrEn = 1'b0; regWrData = '0;
      end
      @(negedge clk);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      regAddr = {1'b1, IDX_W'(c)};
      #1;
      check(regRdData == 16'(expWord(mode, c)), "R9", "result readback",
            regRdData, expWord(mode, c));
    end
    regAddr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(txPulse == '0, "R1", "txPulse after reset", txPulse, 0);
    check(regRdData == 16'h0000, "R1", "status after reset", regRdData, 0);
    check(ramWrEn == 1'b0, "R1", "ramWrEn after reset", ramWrEn, 0);
    runScenario(0, 1'b0);
    runScenario(1, 1'b1);
    runScenario(2, 1'b0);
    runScenario(3, 1'b0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule